// File: doc/BRIEF.md
# Switching Lattice Plate-Connectivity Evaluator

This block evaluates a two-dimensional lattice of four-terminal switches. The lattice is divided into a grid of regions, and each region is expanded into a solid block of switch sites. A configuration table gives every region one literal: an input variable index and a complement bit. When a run is started, every site takes the value of its region's literal for the presented input vector. An ON site joins its four terminals, and an OFF site isolates them.

The block then reports two results. The first is whether a chain of ON sites links the top plate to the bottom plate. The second is whether such a chain links the left plate to the right plate. Both are found by flood propagation, one lattice step per clock. A reach front grows from the ON sites on the entry edge into ON orthogonal neighbours. The run ends when neither front grows in a cycle. A start/done handshake controls the run, and the configuration and input vector are sampled at the accepted start.

Top module: `lat_conn_eval`

## Requirements
- R1: A region at region row i, region column j (row 0 at the top plate, column 0 at the left plate) uses literal index k = i*RCOLS + j. Its variable index is `cfg_var[k*VW +: VW]` and its complement bit is `cfg_neg[k]`. All its sites are ON exactly when `in_vec[var] ^ cfg_neg[k]` is 1. A variable index of NVARS or more reads as 0.
- R2: After a run, `conn_tb` is 1 exactly when a path of orthogonally adjacent ON sites links the top row of sites to the bottom row.
- R3: After a run, `conn_lr` is 1 exactly when a path of orthogonally adjacent ON sites links the left column of sites to the right column.
- R4: Sites that touch only at a corner are not connected, so a diagonal chain of ON regions gives 0 on both outputs.
- R5: Both results equal the connectivity of the region-level literal map, whatever the sub-block size of the regions.
- R6: After reset, `busy`, `done`, `conn_tb` and `conn_lr` are all 0.
- R7: A start while idle makes `busy` 1 and `done` 0 on the next cycle. When the fronts stop growing, `busy` falls and `done` rises in the same cycle, with both results valid.
- R8: A start while `busy` is 1 is ignored. Changes of `in_vec`, `cfg_var` or `cfg_neg` during a run do not affect its results.
- R9: `done`, `conn_tb` and `conn_lr` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| in_vec | input | NVARS | Input variable values |
| cfg_var | input | RROWS*RCOLS*VW | Variable index per region |
| cfg_neg | input | RROWS*RCOLS | Complement bit per region |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid, held until the next start |
| conn_tb | output | 1 | Top-to-bottom plate connectivity |
| conn_lr | output | 1 | Left-to-right plate connectivity |

## Verification
The assertions take `start` to be a clean synchronous level. They also expect configuration and input changes to matter only at an accepted start, so the captured site grid must stay frozen for a whole run. The reach fronts must stay inside ON sites and may only grow. The bench drives every input on the falling clock edge. It deliberately changes `in_vec` and pulses `start` in the middle of a long serpentine run, so that the capture and ignore rules are exercised within those assumptions.

// File: rtl/lat_pkg.sv
package lat_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;

  // Value of a literal given the variable value and the complement bit.
  function automatic logic lit_eval(input logic var_val, input logic neg);
    return var_val ^ neg;
  endfunction

endpackage

// File: rtl/lat_site_map.sv
module lat_site_map #(
  parameter int RROWS = 3,
  parameter int RCOLS = 3,
  parameter int SUB_H = 2,
  parameter int SUB_W = 2,
  parameter int NVARS = 9,
  parameter int VW    = 4
) (
  input  logic [NVARS-1:0]            in_vec,
  input  logic [RROWS*RCOLS*VW-1:0]   cfg_var,
  input  logic [RROWS*RCOLS-1:0]      cfg_neg,
  output logic [RROWS*SUB_H*RCOLS*SUB_W-1:0] site
);
  localparam int NREG = RROWS * RCOLS;
  localparam int GW   = RCOLS * SUB_W;

  function automatic logic pick_var(input logic [NVARS-1:0] v,
                                    input logic [VW-1:0] idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NVARS; k++)
      if (int'(idx) == k) r = v[k];
    return r;
  endfunction

  logic [NREG-1:0] reg_on;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign reg_on[k] = lat_pkg::lit_eval(pick_var(in_vec, cfg_var[k*VW +: VW]),
                                         cfg_neg[k]);
  end

  for (genvar r = 0; r < RROWS*SUB_H; r++) begin : g_row
    for (genvar c = 0; c < GW; c++) begin : g_col
      assign site[r*GW + c] = reg_on[(r/SUB_H)*RCOLS + (c/SUB_W)];
    end
  end
endmodule

// File: rtl/lat_flood.sv
module lat_flood #(
  parameter int GH        = 6,
  parameter int GW        = 6,
  parameter bit FROM_LEFT = 1'b0
) (
  input  logic [GH*GW-1:0] site,
  input  logic [GH*GW-1:0] reach,
  output logic [GH*GW-1:0] nxt,
  output logic             hit
);
  logic [GH*GW-1:0] tgt;

  for (genvar r = 0; r < GH; r++) begin : g_r
    for (genvar c = 0; c < GW; c++) begin : g_c
      localparam int I = r*GW + c;
      logic up, dn, lf, rt, sd;
      if (r > 0)      begin : g_up assign up = reach[I-GW]; end
      else            begin : g_nu assign up = 1'b0;        end
      if (r < GH-1)   begin : g_dn assign dn = reach[I+GW]; end
      else            begin : g_nd assign dn = 1'b0;        end
      if (c > 0)      begin : g_lf assign lf = reach[I-1];  end
      else            begin : g_nl assign lf = 1'b0;        end
      if (c < GW-1)   begin : g_rt assign rt = reach[I+1];  end
      else            begin : g_nr assign rt = 1'b0;        end
      if (FROM_LEFT) begin : g_sl
        assign sd     = (c == 0);
        assign tgt[I] = (c == GW-1);
      end else begin : g_st
        assign sd     = (r == 0);
        assign tgt[I] = (r == GH-1);
      end
      assign nxt[I] = site[I] & (sd | reach[I] | up | dn | lf | rt);
    end
  end

  assign hit = |(reach & tgt);
endmodule

// File: rtl/lat_conn_eval.sv
module lat_conn_eval #(
  parameter int RROWS = 3,
  parameter int RCOLS = 3,
  parameter int SUB_H = 2,
  parameter int SUB_W = 2,
  parameter int NVARS = 9,
  parameter int VW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NVARS-1:0]          in_vec,
  input  logic [RROWS*RCOLS*VW-1:0] cfg_var,
  input  logic [RROWS*RCOLS-1:0]    cfg_neg,
  output logic                      busy,
  output logic                      done,
  output logic                      conn_tb,
  output logic                      conn_lr
);
  import lat_pkg::*;

  localparam int GH    = RROWS * SUB_H;
  localparam int GW    = RCOLS * SUB_W;
  localparam int SITES = GH * GW;

  run_state_t        state;
  logic [SITES-1:0]  site_now, grid_q;
  logic [SITES-1:0]  reach_tb, reach_lr, nxt_tb, nxt_lr;
  logic              hit_tb, hit_lr;
  logic              accept, settle;

  lat_site_map #(.RROWS(RROWS), .RCOLS(RCOLS), .SUB_H(SUB_H), .SUB_W(SUB_W),
                 .NVARS(NVARS), .VW(VW)) u_map (
    .in_vec(in_vec), .cfg_var(cfg_var), .cfg_neg(cfg_neg), .site(site_now));

  lat_flood #(.GH(GH), .GW(GW), .FROM_LEFT(1'b0)) u_tb (
    .site(grid_q), .reach(reach_tb), .nxt(nxt_tb), .hit(hit_tb));

  lat_flood #(.GH(GH), .GW(GW), .FROM_LEFT(1'b1)) u_lr (
    .site(grid_q), .reach(reach_lr), .nxt(nxt_lr), .hit(hit_lr));

  // Named events for the checker.
  assign accept = start && (state == ST_IDLE);
  assign settle = (state == ST_RUN) && (nxt_tb == reach_tb) && (nxt_lr == reach_lr);
  assign busy   = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      grid_q   <= '0;
      reach_tb <= '0;
      reach_lr <= '0;
      done     <= 1'b0;
      conn_tb  <= 1'b0;
      conn_lr  <= 1'b0;
    end else if (accept) begin
      state    <= ST_RUN;
      grid_q   <= site_now;
      reach_tb <= '0;
      reach_lr <= '0;
      done     <= 1'b0;
    end else if (state == ST_RUN) begin
      reach_tb <= nxt_tb;
      reach_lr <= nxt_lr;
      if (settle) begin
        state   <= ST_IDLE;
        done    <= 1'b1;
        conn_tb <= hit_tb;
        conn_lr <= hit_lr;
      end
    end
  end
endmodule

// File: rtl/lat_conn_chk.sv
module lat_conn_chk #(
  parameter int SITES = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             conn_tb,
  input logic             conn_lr,
  input logic             accept,
  input logic [SITES-1:0] grid_q,
  input logic [SITES-1:0] reach_tb,
  input logic [SITES-1:0] reach_lr
);
  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_start_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  p_grid_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(grid_q));

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !accept);

  p_reach_on_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((reach_tb | reach_lr) & ~grid_q) == '0));

  p_reach_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((reach_tb & $past(reach_tb)) == $past(reach_tb)));

  p_reach_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((reach_lr & $past(reach_lr)) == $past(reach_lr)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(conn_tb) && $stable(conn_lr)));
endmodule

bind lat_conn_eval lat_conn_chk #(.SITES(SITES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .conn_tb(conn_tb), .conn_lr(conn_lr), .accept(accept),
  .grid_q(grid_q), .reach_tb(reach_tb), .reach_lr(reach_lr));

// File: tb/tb_lat_conn_eval.sv
`timescale 1ns/1ps
module tb_lat_conn_eval;
  localparam int RR = 3, RC = 3, NV = 9, VW = 4, NR = RR*RC;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NV-1:0]    in_vec = '0;
  logic [NR*VW-1:0] cfg_var = '0;
  logic [NR-1:0]    cfg_neg = '0;
  logic busy, done, conn_tb, conn_lr;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  lat_conn_eval dut (.clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec),
    .cfg_var(cfg_var), .cfg_neg(cfg_neg), .busy(busy), .done(done),
    .conn_tb(conn_tb), .conn_lr(conn_lr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Region-level map from literals (R1 rule restated).
  function automatic logic [NR-1:0] regions(input logic [NR*VW-1:0] cv,
      input logic [NR-1:0] cn, input logic [NV-1:0] v);
    logic [NR-1:0] o;
    for (int k = 0; k < NR; k++) begin
      int idx = int'(cv[k*VW +: VW]);
      logic b = (idx < NV) ? v[idx] : 1'b0;
      o[k] = b ? ~cn[k] : cn[k];
    end
    return o;
  endfunction

  // Relaxation over regions; lr=1 for left-to-right.
  function automatic logic reach_model(input logic [NR-1:0] on, input bit lr);
    logic [NR-1:0] m;
    logic res;
    m = '0;
    for (int i = 0; i < RR; i++)
      for (int j = 0; j < RC; j++)
        if (on[i*RC+j] && ((lr && j == 0) || (!lr && i == 0))) m[i*RC+j] = 1'b1;
    for (int it = 0; it < NR; it++)
      for (int i = 0; i < RR; i++)
        for (int j = 0; j < RC; j++)
          if (on[i*RC+j] && !m[i*RC+j] &&
              ((i > 0 && m[(i-1)*RC+j]) || (i < RR-1 && m[(i+1)*RC+j]) ||
               (j > 0 && m[i*RC+j-1]) || (j < RC-1 && m[i*RC+j+1])))
            m[i*RC+j] = 1'b1;
    res = 1'b0;
    for (int i = 0; i < RR; i++)
      for (int j = 0; j < RC; j++)
        if (m[i*RC+j] && ((lr && j == RC-1) || (!lr && i == RR-1))) res = 1'b1;
    return res;
  endfunction

  function automatic logic [NR*VW-1:0] ident_vars();
    logic [NR*VW-1:0] o;
    for (int k = 0; k < NR; k++) o[k*VW +: VW] = VW'(k);
    return o;
  endfunction

  task automatic launch();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    if (!done) check("R7 run timeout", 0, 1);
  endtask

  task automatic run_cmp(input string req);
    logic [NR-1:0] on;
    on = regions(cfg_var, cfg_neg, in_vec);
    launch();
    wait_done();
    check({req, " tb"}, conn_tb, reach_model(on, 1'b0));
    check({req, " lr"}, conn_lr, reach_model(on, 1'b1));
  endtask

  task automatic t_reset();
    check("R6 busy", busy, 0); check("R6 done", done, 0);
    check("R6 conn_tb", conn_tb, 0); check("R6 conn_lr", conn_lr, 0);
  endtask

  task automatic t_uniform();
    cfg_neg = '0;
    for (int k = 0; k < NR; k++) cfg_var[k*VW +: VW] = 4'd2;
    in_vec = 9'h004; launch(); wait_done();
    check("R1 uniform x=1 tb", conn_tb, 1); check("R1 uniform x=1 lr", conn_lr, 1);
    in_vec = 9'h000; launch(); wait_done();
    check("R2 uniform x=0 tb", conn_tb, 0); check("R3 uniform x=0 lr", conn_lr, 0);
    cfg_neg = '1; launch(); wait_done();
    check("R1 complement tb", conn_tb, 1); check("R1 complement lr", conn_lr, 1);
    cfg_neg = '0;
    for (int k = 0; k < NR; k++) cfg_var[k*VW +: VW] = 4'd12;
    in_vec = '1; launch(); wait_done();
    check("R1 index out of range tb", conn_tb, 0); check("R1 index out of range lr", conn_lr, 0);
  endtask

  task automatic t_diag();
    cfg_var = ident_vars(); cfg_neg = '0;
    in_vec = 9'b100_010_001; launch(); wait_done();
    check("R4 diagonal tb", conn_tb, 0); check("R4 diagonal lr", conn_lr, 0);
    in_vec = 9'b001_010_100; launch(); wait_done();
    check("R4 antidiagonal tb", conn_tb, 0); check("R4 antidiagonal lr", conn_lr, 0);
  endtask

  task automatic t_snake();
    cfg_var = ident_vars(); cfg_neg = '0;
    // regions 0,3,4,5,8 ON: down, across, down
    in_vec = 9'b100_111_001; launch(); wait_done();
    check("R2 snake tb", conn_tb, 1); check("R3 snake lr", conn_lr, 1);
    // only middle row ON
    in_vec = 9'b000_111_000; launch(); wait_done();
    check("R2 bar tb", conn_tb, 0); check("R3 bar lr", conn_lr, 1);
  endtask

  task automatic t_exhaustive();
    cfg_var = ident_vars(); cfg_neg = 9'b101_010_011;
    for (int p = 0; p < 512; p++) begin
      in_vec = 9'(p);
      run_cmp("R5 region map");
    end
  endtask

  task automatic t_busy_ignore();
    cfg_var = ident_vars(); cfg_neg = '0;
    in_vec = 9'b100_111_001;
    launch();
    check("R7 busy after start", busy, 1); check("R7 done cleared", done, 0);
    in_vec = 9'b000_000_000;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done();
    check("R8 ignore tb", conn_tb, 1); check("R8 ignore lr", conn_lr, 1);
    check("R7 busy low at done", busy, 0);
  endtask

  task automatic t_hold();
    in_vec = 9'b000_000_000; cfg_neg = '1;
    repeat (5) @(negedge clk);
    check("R9 hold done", done, 1); check("R9 hold tb", conn_tb, 1);
    check("R9 hold lr", conn_lr, 1);
    cfg_neg = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_uniform();
    t_diag();
    t_snake();
    t_busy_ignore();
    t_hold();
    t_exhaustive();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule